// File: doc/BRIEF.md
# Dual-Channel Indirect Register Interface

This block gives a byte-wide processor bus access to the register file of a two-channel serial controller. Each bus access is split into a port select (control or data) and a channel select, and a swap input exchanges which of the two address bits plays which role. Control accesses reach the internal registers indirectly. The first control write to a channel sets that channel's register pointer, the next control access uses the pointer, and the pointer then falls back to zero without any extra step.

A write to the master control register can carry a reset command that soft-resets either channel or hard-resets both. Data-port writes feed the transmitter. When a channel has both transmit enable and local loopback set, the byte goes straight into that channel's own receive holding register and is not sent out. Data-port reads return the receive holding byte. Read data is registered.

Top module: `sio_regfile`

## Requirements
- R1: After power-on reset, status register 0 of each channel reads 0x04 (transmit buffer empty, bit 2). Every other readable register and the receive holding byte read 0x00, and `tx_valid` is low.
- R2: With `swap`=0, `a[0]` selects the port (0 control, 1 data) and `a[1]` selects the channel (0 = A, 1 = B). With `swap`=1 the two roles are exchanged.
- R3: A control write while the pointer is zero loads the pointer from `din[2:0]`. When `din[5:3]` is 001, the pointer also gets 8 added. Any other command code loads only bits 2:0.
- R4: A control read returns the read register chosen by the pointer: 0 is status, 1 is special status, 12 and 13 are the baud divisor mirrors, and any other number reads 0x00. Any control access made with a nonzero pointer returns the pointer to zero, and so does every control read.
- R5: Bytes written to write registers 12 and 13 read back through read registers 12 and 13 of the same channel. Soft and hard resets leave these bytes unchanged.
- R6: A write to register 9 whose bits 7:6 are 01 soft-resets channel B, 10 soft-resets channel A, and 11 hard-resets both channels. The channel that is not named keeps its state.
- R7: A soft reset clears receive-available (status bit 0), sets the transmit-empty and underrun bits (status bits 2 and 6), sets special-status bits 2:1 and keeps bit 0. It also clears the transmit enable bit (write register 5 bit 3) and the local-loopback bit (write register 14 bit 4).
- R8: A hard reset does everything a soft reset does and also sets the local-loopback bit of both channels.
- R9: A data write sets transmit-empty and all-sent (special status bit 0). A write to write register 4 also sets all-sent. With transmit enabled and loopback clear, `tx_valid` pulses for one cycle, starting one cycle after the write, with `tx_chan` and `tx_data`. With transmit disabled there is no pulse.
- R10: With transmit enabled and loopback set, a data write places the byte in the same channel's receive holding register and sets receive-available, and `tx_valid` does not pulse.
- R11: A data read returns the receive holding byte and clears receive-available.
- R12: `dout` changes only in the cycle after a read access and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs | input | 1 | Access select |
| rd | input | 1 | Read strobe (ignored while wr is high) |
| wr | input | 1 | Write strobe |
| swap | input | 1 | Exchanges the roles of the two address bits |
| a | input | 2 | Port and channel select bits |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| tx_valid | output | 1 | One-cycle pulse for a byte sent to the transmitter |
| tx_chan | output | 1 | Channel of the transmitted byte |
| tx_data | output | 8 | Transmitted byte |

## Verification
If a pointer is left in the wrong state, the very next control access on that channel hits the wrong register. This shows up as the wrong byte on `dout` one cycle after that access. A misdecoded reset command shows on the first status read of the channel it should or should not have touched. Loss of the transmit-enable or loopback bits shows on the next data write, either through `tx_valid` or through the receive-available bit. The tests therefore always pair each state-changing access with the earliest read or pulse that could reveal it.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int NCH  = 2;
    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int PW   = $clog2(NREG);
    localparam int CW   = $clog2(NCH);

    typedef logic [DW-1:0] byte_t;
    typedef logic [PW-1:0] ptr_t;

    // reset command field of the master register
    localparam logic [1:0] RST_NONE = 2'b00;
    localparam logic [1:0] RST_ALL  = 2'b11;

    // register numbers whose behaviour is special
    localparam ptr_t REG_CMD    = 4'd0;
    localparam ptr_t REG_SPEC   = 4'd1;
    localparam ptr_t REG_INTCFG = 4'd1;
    localparam ptr_t REG_RXCFG  = 4'd3;
    localparam ptr_t REG_FMT    = 4'd4;
    localparam ptr_t REG_TXCFG  = 4'd5;
    localparam ptr_t REG_MASTER = 4'd9;
    localparam ptr_t REG_ENC    = 4'd10;
    localparam ptr_t REG_CLKSEL = 4'd11;
    localparam ptr_t REG_BRG_LO = 4'd12;
    localparam ptr_t REG_BRG_HI = 4'd13;
    localparam ptr_t REG_LOOPCF = 4'd14;
    localparam ptr_t REG_EXTEN  = 4'd15;

    localparam logic [2:0] CMD_POINT_HI = 3'b001;

    // bit positions
    localparam int ST_RXAV   = 0;
    localparam int ST_TXE    = 2;
    localparam int ST_UNDR   = 6;
    localparam int SP_ALLSNT = 0;
    localparam int TXEN_BIT  = 3;
    localparam int LOOP_BIT  = 4;
    localparam int RXEN_BIT  = 0;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] wr;
        byte_t st0;
        byte_t st1;
        byte_t rxd;
        ptr_t  ptr;
    } chan_t;

    typedef struct packed {
        logic ctrl_wr;
        logic ctrl_rd;
        logic data_wr;
        logic data_rd;
    } acc_t;

    function automatic chan_t chan_por();
        chan_t c;
        c = '0;
        c.st0[ST_TXE] = 1'b1;
        return c;
    endfunction

    function automatic chan_t chan_soft(chan_t c);
        chan_t n;
        n = c;
        n.ptr                   = '0;
        n.wr[REG_CMD]           = '0;
        n.wr[REG_INTCFG]        = c.wr[REG_INTCFG] & 8'h24;
        n.wr[REG_RXCFG][RXEN_BIT] = 1'b0;
        n.wr[REG_FMT]           = c.wr[REG_FMT] | 8'h04;
        n.wr[REG_TXCFG]         = c.wr[REG_TXCFG] & 8'h61;
        n.wr[REG_MASTER]        = c.wr[REG_MASTER] & 8'hDF;
        n.wr[REG_ENC]           = c.wr[REG_ENC] & 8'h60;
        n.wr[REG_LOOPCF]        = (c.wr[REG_LOOPCF] & 8'hC3) | 8'h20;
        n.wr[REG_EXTEN]         = 8'hF8;
        n.st0                   = (c.st0 & 8'hB8) | 8'h44;
        n.st1                   = (c.st1 & 8'h01) | 8'h06;
        return n;
    endfunction

    function automatic chan_t chan_hard(chan_t c);
        chan_t n;
        n = chan_soft(c);
        n.wr[REG_MASTER] = (n.wr[REG_MASTER] & 8'h03) | 8'hC0;
        n.wr[REG_ENC]    = '0;
        n.wr[REG_CLKSEL] = 8'h08;
        n.wr[REG_LOOPCF] = (n.wr[REG_LOOPCF] & 8'hC0) | 8'h30;
        return n;
    endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_pkg::*;
(
    input  logic                 cs,
    input  logic                 rd,
    input  logic                 wr,
    input  logic                 swap,
    input  logic [1:0]           a,
    output acc_t [NCH-1:0]       acc_o,
    output logic [CW-1:0]        ch_o,
    output logic                 is_data_o,
    output logic                 rd_hit_o
);
    logic port_bit;
    logic do_wr;
    logic do_rd;

    assign port_bit  = swap ? a[1] : a[0];
    assign ch_o      = swap ? a[0] : a[1];
    assign is_data_o = port_bit;
    assign do_wr     = cs && wr;
    assign do_rd     = cs && rd && !wr;
    assign rd_hit_o  = do_rd;

    for (genvar g = 0; g < NCH; g++) begin : g_acc
        logic hit;
        assign hit = (ch_o == CW'(g));
        assign acc_o[g].ctrl_wr = hit && do_wr && !port_bit;
        assign acc_o[g].ctrl_rd = hit && do_rd && !port_bit;
        assign acc_o[g].data_wr = hit && do_wr &&  port_bit;
        assign acc_o[g].data_rd = hit && do_rd &&  port_bit;
    end
endmodule

// File: rtl/sio_channel.sv
module sio_channel
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_t       acc_i,
    input  byte_t      din_i,
    input  logic       soft_i,
    input  logic       hard_i,
    output byte_t      ctrl_val_o,
    output byte_t      rxd_o,
    output logic       tx_fire_o,
    output ptr_t       ptr_o,
    output logic [1:0] rst_cmd_o
);
    chan_t cur;
    chan_t nxt;

    always_comb begin
        nxt       = cur;
        tx_fire_o = 1'b0;
        rst_cmd_o = RST_NONE;
        if (acc_i.ctrl_wr) begin
            if (cur.ptr == '0) begin
                nxt.ptr = {(din_i[5:3] == CMD_POINT_HI), din_i[2:0]};
            end else begin
                nxt.ptr = '0;
                if (cur.ptr == REG_MASTER && din_i[7:6] != RST_NONE) begin
                    rst_cmd_o = din_i[7:6];
                end else begin
                    nxt.wr[cur.ptr] = din_i;
                    if (cur.ptr == REG_FMT) begin
                        nxt.st1[SP_ALLSNT] = 1'b1;
                    end
                end
            end
        end else if (acc_i.ctrl_rd) begin
            nxt.ptr = '0;
        end else if (acc_i.data_wr) begin
            nxt.st0[ST_TXE]    = 1'b1;
            nxt.st1[SP_ALLSNT] = 1'b1;
            if (cur.wr[REG_TXCFG][TXEN_BIT]) begin
                if (cur.wr[REG_LOOPCF][LOOP_BIT]) begin
                    nxt.rxd          = din_i;
                    nxt.st0[ST_RXAV] = 1'b1;
                end else begin
                    tx_fire_o = 1'b1;
                end
            end
        end else if (acc_i.data_rd) begin
            nxt.st0[ST_RXAV] = 1'b0;
        end
    end

    always_comb begin
        case (cur.ptr)
            REG_CMD:    ctrl_val_o = cur.st0;
            REG_SPEC:   ctrl_val_o = cur.st1;
            REG_BRG_LO: ctrl_val_o = cur.wr[REG_BRG_LO];
            REG_BRG_HI: ctrl_val_o = cur.wr[REG_BRG_HI];
            default:    ctrl_val_o = '0;
        endcase
    end

    assign rxd_o = cur.rxd;
    assign ptr_o = cur.ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= chan_por();
        end else if (hard_i) begin
            cur <= chan_hard(cur);
        end else if (soft_i) begin
            cur <= chan_soft(cur);
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic       swap,
    input  logic [1:0] a,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       tx_valid,
    output logic       tx_chan,
    output logic [7:0] tx_data
);
    acc_t [NCH-1:0]        acc;
    logic [CW-1:0]         sel_ch;
    logic                  is_data;
    logic                  rd_hit;
    byte_t [NCH-1:0]       ctrl_v;
    byte_t [NCH-1:0]       rxd_v;
    logic [NCH-1:0]        fire_v;
    ptr_t [NCH-1:0]        ptr_v;
    logic [NCH-1:0][1:0]   cmd_v;
    logic [1:0]            rst_any;
    logic                  hard_all;
    logic [NCH-1:0]        soft_v;
    logic                  ctrl_acc;
    logic                  ctrl_wr_any;

    sio_addr_decode u_dec (
        .cs        (cs),
        .rd        (rd),
        .wr        (wr),
        .swap      (swap),
        .a         (a),
        .acc_o     (acc),
        .ch_o      (sel_ch),
        .is_data_o (is_data),
        .rd_hit_o  (rd_hit)
    );

    always_comb begin
        rst_any     = RST_NONE;
        ctrl_acc    = 1'b0;
        ctrl_wr_any = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            rst_any     = rst_any | cmd_v[i];
            ctrl_acc    = ctrl_acc | acc[i].ctrl_wr | acc[i].ctrl_rd;
            ctrl_wr_any = ctrl_wr_any | acc[i].ctrl_wr;
        end
    end

    assign hard_all = (rst_any == RST_ALL);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // command bit 1 names channel A (index 0), bit 0 names channel B
        assign soft_v[g] = !hard_all && rst_any[NCH-1-g];

        sio_channel u_chan (
            .clk        (clk),
            .rst        (rst),
            .acc_i      (acc[g]),
            .din_i      (din),
            .soft_i     (soft_v[g]),
            .hard_i     (hard_all),
            .ctrl_val_o (ctrl_v[g]),
            .rxd_o      (rxd_v[g]),
            .tx_fire_o  (fire_v[g]),
            .ptr_o      (ptr_v[g]),
            .rst_cmd_o  (cmd_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (rd_hit) begin
            dout <= is_data ? rxd_v[sel_ch] : ctrl_v[sel_ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_chan  <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= |fire_v;
            if (|fire_v) begin
                tx_chan <= sel_ch;
                tx_data <= din;
            end
        end
    end
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk
    import sio_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cs,
    input logic                rd,
    input logic                wr,
    input logic [2:0]          cmd_field,
    input logic [7:0]          dout,
    input logic                tx_valid,
    input logic [CW-1:0]       sel_ch,
    input logic                is_data,
    input logic                ctrl_acc,
    input logic                ctrl_wr_any,
    input ptr_t [NCH-1:0]      ptr_v
);
    assert_ptr_return_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_acc && ptr_v[sel_ch] != '0) |=> (ptr_v[$past(sel_ch)] == '0));

    assert_point_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_any && ptr_v[sel_ch] == '0 && cmd_field == CMD_POINT_HI)
        |=> ptr_v[$past(sel_ch)][PW-1]);

    assert_dout_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd && !wr) |=> $stable(dout));

    assert_tx_from_write_R9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(cs && wr && is_data));
endmodule

bind sio_regfile sio_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .rd          (rd),
    .wr          (wr),
    .cmd_field   (din[5:3]),
    .dout        (dout),
    .tx_valid    (tx_valid),
    .sel_ch      (sel_ch),
    .is_data     (is_data),
    .ctrl_acc    (ctrl_acc),
    .ctrl_wr_any (ctrl_wr_any),
    .ptr_v       (ptr_v)
);

// File: tb/sio_regfile_tb.sv
module sio_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs, rd, wr, swap;
    logic [1:0] a;
    logic [7:0] din;
    logic [7:0] dout;
    logic       tx_valid, tx_chan;
    logic [7:0] tx_data;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic CHA = 1'b0;
    localparam logic CHB = 1'b1;

    always #5 clk = ~clk;

    sio_regfile dut_i (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .swap(swap),
        .a(a), .din(din), .dout(dout), .tx_valid(tx_valid),
        .tx_chan(tx_chan), .tx_data(tx_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic isw, input logic port, input logic ch, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = isw; rd = !isw; din = d;
        a  = swap ? {port, ch} : {ch, port};
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; rd = 1'b0;
    endtask

    task automatic cw(input logic ch, input logic [7:0] v);
        bus(1'b1, 1'b0, ch, v);
    endtask

    task automatic dw(input logic ch, input logic [7:0] v);
        bus(1'b1, 1'b1, ch, v);
    endtask

    task automatic set_ptr(input logic ch, input int r);
        if (r >= 8) cw(ch, 8'h08 | 8'(r % 8));
        else if (r != 0) cw(ch, 8'(r));
    endtask

    task automatic wreg(input logic ch, input int r, input logic [7:0] v);
        set_ptr(ch, r);
        cw(ch, v);
    endtask

    task automatic rreg(input logic ch, input int r, output logic [7:0] v);
        set_ptr(ch, r);
        bus(1'b0, 1'b0, ch, 8'h00);
        v = dout;
    endtask

    task automatic drd(input logic ch, output logic [7:0] v);
        bus(1'b0, 1'b1, ch, 8'h00);
        v = dout;
    endtask

    task automatic t_por();
        logic [7:0] v;
        check("R1 tx_valid idle", {7'd0, tx_valid}, 8'h00);
        rreg(CHA, 0, v);  check("R1 status A", v, 8'h04);
        rreg(CHB, 0, v);  check("R1 status B", v, 8'h04);
        rreg(CHA, 1, v);  check("R1 special A", v, 8'h00);
        rreg(CHB, 13, v); check("R1 brg hi B", v, 8'h00);
        drd(CHA, v);      check("R1 rx hold A", v, 8'h00);
    endtask

    task automatic t_brg();
        logic [7:0] v;
        wreg(CHA, 12, 8'h5A);
        wreg(CHA, 13, 8'hC3);
        wreg(CHB, 12, 8'h11);
        rreg(CHA, 12, v); check("R5 brg lo A", v, 8'h5A);
        rreg(CHA, 13, v); check("R5 brg hi A", v, 8'hC3);
        rreg(CHB, 12, v); check("R5 brg lo B", v, 8'h11);
        rreg(CHA, 7, v);  check("R4 unmapped reads zero", v, 8'h00);
    endtask

    task automatic t_ptr();
        logic [7:0] v;
        // command code 101 with pointer 4: only bits 2:0 are taken
        cw(CHA, 8'h2C);
        cw(CHA, 8'h77);
        rreg(CHA, 12, v); check("R3 other command no +8", v, 8'h5A);
        rreg(CHA, 1, v);  check("R9 reg4 write sets all-sent", v, 8'h01);
        cw(CHA, 8'h0C);   // point-high with 4 -> 12
        bus(1'b0, 1'b0, CHA, 8'h00);
        check("R3 point high reaches 12", dout, 8'h5A);
        bus(1'b0, 1'b0, CHA, 8'h00);
        check("R4 pointer back to zero after read", dout, 8'h04);
        dw(CHA, 8'h00);
        check("R12 dout holds across write", dout, 8'h04);
        check("R9 no pulse with tx disabled", {7'd0, tx_valid}, 8'h00);
    endtask

    task automatic t_data_tx();
        logic [7:0] v;
        wreg(CHB, 5, 8'h08);
        dw(CHB, 8'h3C);
        check("R9 tx_valid pulse", {7'd0, tx_valid}, 8'h01);
        check("R9 tx_chan", {7'd0, tx_chan}, 8'h01);
        check("R9 tx_data", tx_data, 8'h3C);
        @(negedge clk);
        check("R9 pulse one cycle", {7'd0, tx_valid}, 8'h00);
        rreg(CHB, 1, v); check("R9 all-sent after data write", v, 8'h01);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        wreg(CHA, 14, 8'h10);
        wreg(CHA, 5, 8'h08);
        dw(CHA, 8'hA5);
        check("R10 no tx pulse in loopback", {7'd0, tx_valid}, 8'h00);
        rreg(CHA, 0, v); check("R10 rx avail set", v, 8'h05);
        drd(CHA, v);     check("R11 rx byte returned", v, 8'hA5);
        rreg(CHA, 0, v); check("R11 rx avail cleared", v, 8'h04);
    endtask

    task automatic t_soft();
        logic [7:0] v;
        dw(CHA, 8'h66);
        rreg(CHA, 0, v); check("R10 loop byte pending", v, 8'h05);
        wreg(CHB, 9, 8'h80);          // soft reset A issued from B
        rreg(CHA, 0, v);  check("R7 status A after soft", v, 8'h44);
        rreg(CHA, 1, v);  check("R7 special A after soft", v, 8'h07);
        rreg(CHA, 12, v); check("R5 brg kept over soft", v, 8'h5A);
        rreg(CHB, 0, v);  check("R6 B untouched status", v, 8'h04);
        rreg(CHB, 1, v);  check("R6 B untouched special", v, 8'h01);
        dw(CHA, 8'h11);
        check("R7 tx enable cleared", {7'd0, tx_valid}, 8'h00);
        rreg(CHA, 0, v);  check("R7 no loopback after soft", v, 8'h44);
        wreg(CHA, 5, 8'h08);
        dw(CHA, 8'h22);
        check("R7 loopback cleared so byte sent", {7'd0, tx_valid}, 8'h01);
        check("R7 tx_chan A", {7'd0, tx_chan}, 8'h00);
        check("R7 tx_data", tx_data, 8'h22);
        wreg(CHA, 9, 8'h40);          // soft reset B issued from A
        rreg(CHB, 0, v);  check("R6 B status after soft", v, 8'h44);
        rreg(CHB, 1, v);  check("R6 B special after soft", v, 8'h07);
        rreg(CHA, 0, v);  check("R6 A untouched by B reset", v, 8'h44);
    endtask

    task automatic t_hard();
        logic [7:0] v;
        wreg(CHB, 9, 8'hC0);
        rreg(CHA, 0, v);  check("R6 hard status A", v, 8'h44);
        rreg(CHA, 1, v);  check("R6 hard special A", v, 8'h07);
        wreg(CHB, 5, 8'h08);
        dw(CHB, 8'h99);
        check("R8 loopback set by hard reset", {7'd0, tx_valid}, 8'h00);
        rreg(CHB, 0, v);  check("R8 rx avail B", v, 8'h45);
        drd(CHB, v);      check("R8 looped byte B", v, 8'h99);
        rreg(CHA, 12, v); check("R5 brg kept over hard", v, 8'h5A);
    endtask

    task automatic t_swap();
        logic [7:0] v;
        swap = 1'b1;
        rreg(CHA, 12, v); check("R2 swapped read A", v, 8'h5A);
        rreg(CHB, 12, v); check("R2 swapped read B", v, 8'h11);
        rreg(CHB, 0, v);  check("R2 swapped status B", v, 8'h44);
        swap = 1'b0;
        rreg(CHB, 12, v); check("R2 normal read B", v, 8'h11);
    endtask

    initial begin
        cs = 0; rd = 0; wr = 0; swap = 0; a = 0; din = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_por();
        t_brg();
        t_ptr();
        t_data_tx();
        t_loop();
        t_soft();
        t_hard();
        t_swap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule